// File: doc/BRIEF.md
# Iterative Unsigned Integer Divider

This block divides one unsigned integer by another over many clock cycles and returns both the quotient and the remainder. A caller presents the dividend, the divisor and a mode bit together with a single-cycle `start` pulse. The block then runs one iteration per clock cycle, with one quotient bit per iteration, and pulses `done` when the results are ready. The remainder appears on `hi` and the quotient on `lo`. Both stay unchanged until the next accepted `start`.

The mode bit selects one of two iteration schemes, and both give identical results:

- **Restoring.** When a trial subtraction goes negative, the block keeps the shifted partial remainder.
- **Non-restoring.** The block keeps the negative partial remainder. The next step adds the divisor instead of subtracting it. A final corrective addition runs only when the last partial remainder is negative.

A zero divisor is flagged and not iterated.

Top module: `divu_iter`

## Requirements
- R1: In restoring mode (`nonrestore`=0) with a nonzero divisor, `lo` equals dividend / divisor and `hi` equals dividend mod divisor when `done` is high.
- R2: In non-restoring mode (`nonrestore`=1) with a nonzero divisor, `lo` and `hi` give the same quotient and remainder as in R1.
- R3: In restoring mode with a nonzero divisor, `done` goes high exactly W clock edges after the edge that accepts `start`.
- R4: In non-restoring mode with a nonzero divisor, `done` goes high W edges after the accepting edge when the quotient is odd. When the quotient is even, the final partial remainder is negative, so a correction cycle is added and `done` goes high after W+1 edges.
- R5: A zero divisor makes `done` and `div_by_zero` go high on the accepting edge itself, with `lo` all ones and `hi` equal to the dividend. A nonzero divisor leaves `div_by_zero` low.
- R6: `busy` is high from the accepting edge of a nonzero-divisor division until `done` rises. `done` is a one-cycle pulse that is never high together with `busy`.
- R7: A `start` raised while `busy` is high is ignored. The running division completes with its original operands.
- R8: `hi`, `lo` and `div_by_zero` hold their values while the block is idle and no `start` is raised.
- R9: After reset, `busy`, `done` and `div_by_zero` are 0, and `hi` and `lo` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; accepted only while idle |
| nonrestore | input | 1 | 0 = restoring iteration, 1 = non-restoring iteration |
| dividend | input | W | Dividend, unsigned |
| divisor | input | W | Divisor, unsigned |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: results valid |
| div_by_zero | output | 1 | The last accepted divisor was zero |
| hi | output | W | Remainder |
| lo | output | W | Quotient |

## Verification
A 4-bit instance is swept over every dividend and divisor pair in both modes. This covers zero divisors, divisors larger than the dividend, exact multiples, and even and odd quotients. It therefore separates the restoring keep-path from the non-restoring add-next path, and it shows whether the correction cycle happens exactly when the quotient is even. A 32-bit instance runs small worked cases and operands at the edges of the range: an all-ones dividend, divisor one, and a divisor with the top bit set. These cases exercise the extra sign bit of the partial remainder. One case raises `start` again in mid-division with other operands to show it is ignored.

// File: rtl/divu_iter.sv
module divu_iter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         nonrestore,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         div_by_zero,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int CW = $clog2(W + 1);

  typedef enum logic [1:0] {IDLE, RUN, FIX} st_t;

  st_t           st;
  logic          mode_q;
  logic [W:0]    rem;
  logic [W-1:0]  quo, dvs;
  logic [CW-1:0] cnt;

  wire [W+1:0] shl    = {rem, quo[W-1]};
  wire [W+1:0] dext   = {2'b00, dvs};
  wire         sub_op = ~mode_q | ~rem[W];
  wire [W+1:0] sum    = sub_op ? shl - dext : shl + dext;
  wire         neg    = sum[W+1];
  wire [W:0]   rem_nx = (!mode_q && neg) ? shl[W:0] : sum[W:0];
  wire         last   = (cnt == CW'(W - 1));

  assign busy = (st != IDLE);
  assign hi   = rem[W-1:0];
  assign lo   = quo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= IDLE;
      mode_q      <= 1'b0;
      rem         <= '0;
      quo         <= '0;
      dvs         <= '0;
      cnt         <= '0;
      done        <= 1'b0;
      div_by_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        IDLE: if (start) begin
          mode_q      <= nonrestore;
          dvs         <= divisor;
          div_by_zero <= (divisor == '0);
          cnt         <= '0;
          if (divisor == '0) begin
            rem  <= {1'b0, dividend};
            quo  <= '1;
            done <= 1'b1;
          end else begin
            rem <= '0;
            quo <= dividend;
            st  <= RUN;
          end
        end
        RUN: begin
          rem <= rem_nx;
          quo <= {quo[W-2:0], ~neg};
          cnt <= cnt + 1'b1;
          if (last) begin
            if (mode_q && neg) st <= FIX;
            else begin
              st   <= IDLE;
              done <= 1'b1;
            end
          end
        end
        FIX: begin
          rem  <= rem + {1'b0, dvs};
          st   <= IDLE;
          done <= 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/divu_iter_chk.sv
module divu_iter_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic         div_by_zero,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  logic [W-1:0] dq;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dq <= '0;
    else if (start && !busy) dq <= divisor;

  assert_rem_below_divisor_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero) |-> (hi < dq));

  assert_zero_div_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_by_zero) |-> (lo == {W{1'b1}}));

  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(hi) && $stable(lo) && $stable(div_by_zero)));
endmodule

bind divu_iter divu_iter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .divisor(divisor),
  .busy(busy), .done(done), .div_by_zero(div_by_zero), .hi(hi), .lo(lo)
);

// File: tb/tb_divu_iter.sv
module tb_divu_iter;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(PERIOD / 2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic        st32 = 1'b0, md32 = 1'b0;
  logic [31:0] a32 = '0, d32 = '0;
  logic        busy32, done32, dz32;
  logic [31:0] hi32, lo32;

  logic        st4 = 1'b0, md4 = 1'b0;
  logic [3:0]  a4 = '0, d4 = '0;
  logic        busy4, done4, dz4;
  logic [3:0]  hi4, lo4;

  divu_iter #(.W(32)) dut (
    .clk(clk), .rst_n(rst_n), .start(st32), .nonrestore(md32),
    .dividend(a32), .divisor(d32), .busy(busy32), .done(done32),
    .div_by_zero(dz32), .hi(hi32), .lo(lo32));

  divu_iter #(.W(4)) dut_s (
    .clk(clk), .rst_n(rst_n), .start(st4), .nonrestore(md4),
    .dividend(a4), .divisor(d4), .busy(busy4), .done(done4),
    .div_by_zero(dz4), .hi(hi4), .lo(lo4));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run4(input logic [3:0] a, input logic [3:0] d, input logic m);
    int lat, elat;
    logic [3:0] eq, er;
    string rq;
    @(negedge clk);
    a4 = a; d4 = d; md4 = m; st4 = 1'b1;
    @(negedge clk);
    st4 = 1'b0;
    lat = 1;
    while (!done4 && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    eq   = (d == 0) ? 4'hF : a / d;
    er   = (d == 0) ? a : a % d;
    elat = (d == 0) ? 1 : 5 + ((m && !eq[0]) ? 1 : 0);
    rq   = m ? "R2" : "R1";
    if (d == 0) rq = "R5";
    chk(lo4 == eq, rq, "quotient4", lo4, eq);
    chk(hi4 == er, rq, "remainder4", hi4, er);
    chk(dz4 == (d == 0), "R5", "dbz flag4", dz4, d == 0);
    if (d != 0) chk(lat == elat, m ? "R4" : "R3", "latency4", lat, elat);
    else chk(lat == elat, "R5", "latency4", lat, elat);
  endtask

  task automatic run32(input logic [31:0] a, input logic [31:0] d, input logic m,
                       input bit poke);
    int lat, elat;
    logic [31:0] eq, er;
    bit busy_ok;
    @(negedge clk);
    a32 = a; d32 = d; md32 = m; st32 = 1'b1;
    @(negedge clk);
    st32 = 1'b0;
    lat = 1;
    busy_ok = (d == 0) ? !busy32 : busy32;
    while (!done32 && lat < 60) begin
      if (poke && lat == 5) begin
        a32 = 32'd1000; d32 = 32'd7; md32 = ~m; st32 = 1'b1;
      end else st32 = 1'b0;
      @(negedge clk);
      st32 = 1'b0;
      if (!done32 && !busy32) busy_ok = 1'b0;
      lat++;
    end
    eq   = (d == 0) ? 32'hFFFF_FFFF : a / d;
    er   = (d == 0) ? a : a % d;
    elat = (d == 0) ? 1 : 33 + ((m && !eq[0]) ? 1 : 0);
    chk(lo32 == eq, poke ? "R7" : (m ? "R2" : "R1"), "quotient32", lo32, eq);
    chk(hi32 == er, poke ? "R7" : (m ? "R2" : "R1"), "remainder32", hi32, er);
    chk(lat == elat, m ? "R4" : "R3", "latency32", lat, elat);
    chk(busy_ok && !busy32, "R6", "busy window", busy32, 0);
    @(negedge clk);
    chk(!done32, "R6", "done pulse width", done32, 0);
    repeat (3) @(negedge clk);
    chk(lo32 == eq && hi32 == er, "R8", "hold after done", lo32, eq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy32 && !done32 && !dz32, "R9", "reset flags", busy32, 0);
    chk(hi32 == 0 && lo32 == 0, "R9", "reset results", lo32, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 16; a++)
        for (int d = 0; d < 16; d++)
          run4(4'(a), 4'(d), m[0]);

    for (int m = 0; m < 2; m++) begin
      run32(32'd6, 32'd2, m[0], 1'b0);
      run32(32'd7, 32'd2, m[0], 1'b0);
      run32(32'd11, 32'd3, m[0], 1'b0);
      run32(32'hFFFF_FFFF, 32'd1, m[0], 1'b0);
      run32(32'hFFFF_FFFF, 32'h8000_0001, m[0], 1'b0);
      run32(32'h1234_5678, 32'hFFFF_FFFF, m[0], 1'b0);
      run32(32'hDEAD_BEEF, 32'h0001_0003, m[0], 1'b0);
      run32(32'h0BAD_F00D, 32'd0, m[0], 1'b0);
      run32(32'd100, 32'd9, m[0], 1'b1);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule